// File: doc/BRIEF.md
# Data Memory Address Generator

This block forms the effective data-memory address for the load and store instructions of an 8-bit CPU. Each access gives an addressing-mode code, a pointer select, a 6-bit unsigned displacement and a 16-bit direct address. The block also receives the six top general-purpose register bytes, which hold three 16-bit pointers. The effective address is combinational from these inputs, so the memory stage can use it in the same cycle.

In the two auto-modify modes the block also returns the updated pointer value. This write-back is registered on the clock edge at which the access is issued. Both bytes of the selected pair are written together, and the register file receives the index of the low byte. Combinations that cannot be encoded raise an illegal flag and suppress any write-back. Instruction decoding, the remaining registers and the memory access itself are handled outside this block.

Top module: `dmag_top`

## Requirements
- R1: With mode code 0 (direct), `ea_o` equals `direct_i` for any pointer select, `illegal_o` is 0, and no write-back follows.
- R2: The pointers are X = {r27,r26}, Y = {r29,r28} and Z = {r31,r30}, where register byte k (r26+k) sits at `regs_i[8k+7:8k]`. Select codes are X=0, Y=1, Z=2. With mode code 1 (indirect), `ea_o` is the selected pointer and no write-back follows. A write-back reports `wb_idx_o` as 26, 28 or 30 for X, Y or Z.
- R3: With mode code 3 (pre-decrement), `ea_o` is the selected pointer minus one, modulo 2^16. The write-back value equals that same address.
- R4: With mode code 4 (post-increment), `ea_o` is the unmodified pointer. The write-back value is the pointer plus one, modulo 2^16.
- R5: With mode code 2 (displacement), `ea_o` is Y or Z plus the zero-extended 6-bit `disp_i` (0 to 63), modulo 2^16. No write-back follows.
- R6: `illegal_o` is 1, `ea_o` is 0 and no write-back follows in three cases: mode code 2 with X selected, select code 3 in any pointer mode, or mode codes 5 to 7.
- R7: `wb_en_o` is 1 for exactly the cycle after a rising edge at which `req_i` was 1 with a legal mode 3 or 4. `wb_data_o` and `wb_idx_o` are valid in that cycle. Without `req_i`, no write-back occurs.
- R8: While `rst_ni` is low, `wb_en_o`, `wb_data_o` and `wb_idx_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access issued this cycle |
| mode_i | input | 3 | Addressing-mode code |
| ptr_sel_i | input | 2 | Pointer select (X=0, Y=1, Z=2) |
| disp_i | input | 6 | Unsigned displacement |
| direct_i | input | 16 | Direct address |
| regs_i | input | 48 | Register bytes r26..r31, r26 in the low byte |
| ea_o | output | 16 | Effective address |
| illegal_o | output | 1 | Unencodable mode/pointer combination |
| wb_en_o | output | 1 | Pointer write-back enable |
| wb_idx_o | output | 5 | Low-byte register index of the written pair |
| wb_data_o | output | 16 | New pointer value |

## Verification
The directed cases target the wrap points. Pre-decrementing 0x0000 must give 0xFFFF, post-incrementing 0xFFFF must give 0x0000, and 0xFFC1 plus 63 must wrap to 0x0000. A design that carried into a 17th bit or dropped the borrow would fail these cases. The bench also drives displacement with X, select code 3 and the reserved modes. A design that decoded loosely would produce an address or a write-back in those cases instead of the flag. Random requests with `req_i` toggling check that a write-back appears for exactly one cycle after an issued auto-modify access. A write-back that lagged, stuck high or ignored `req_i` is therefore caught. Byte order and the pair index are checked on every write-back.

// File: rtl/dmag_pkg.sv
package dmag_pkg;
  localparam int unsigned ADDR_W   = 16;
  localparam int unsigned DISP_W   = 6;
  localparam int unsigned NUM_PTR  = 3;
  localparam int unsigned SEL_W    = 2;
  localparam int unsigned MODE_W   = 3;
  localparam int unsigned RIDX_W   = 5;
  localparam int unsigned PTR_BASE = 26;

  typedef enum logic [MODE_W-1:0] {
    AM_DIRECT  = 3'd0,
    AM_IND     = 3'd1,
    AM_DISP    = 3'd2,
    AM_PREDEC  = 3'd3,
    AM_POSTINC = 3'd4
  } am_e;

  localparam logic [SEL_W-1:0] PS_X = 2'd0;
  localparam logic [SEL_W-1:0] PS_Y = 2'd1;
  localparam logic [SEL_W-1:0] PS_Z = 2'd2;
endpackage

// File: rtl/dmag_ptr_mux.sv
module dmag_ptr_mux
  import dmag_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned NP = NUM_PTR,
  parameter int unsigned SW = SEL_W
) (
  input  logic [2*NP*8-1:0] regs_i,
  input  logic [SW-1:0]     sel_i,
  output logic [AW-1:0]     ptr_o,
  output logic              sel_ok_o
);
  logic [AW-1:0] ptr_arr [NP];

  for (genvar g = 0; g < NP; g++) begin : g_pair
    assign ptr_arr[g] = {regs_i[(2*g+1)*8 +: 8], regs_i[(2*g)*8 +: 8]};
  end

  always_comb begin
    ptr_o    = '0;
    sel_ok_o = 1'b0;
    for (int i = 0; i < NP; i++) begin
      if (sel_i == SW'(i)) begin
        ptr_o    = ptr_arr[i];
        sel_ok_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dmag_ea_calc.sv
module dmag_ea_calc
  import dmag_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DISP_W,
  parameter int unsigned SW = SEL_W
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic [SW-1:0]     sel_i,
  input  logic              sel_ok_i,
  input  logic [DW-1:0]     disp_i,
  input  logic [AW-1:0]     direct_i,
  input  logic [AW-1:0]     ptr_i,
  output logic [AW-1:0]     ea_o,
  output logic [AW-1:0]     wb_val_o,
  output logic              wb_need_o,
  output logic              illegal_o
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] ptr_dec, ptr_inc, ptr_dsp;

  assign ptr_dec = ptr_i - ONE;
  assign ptr_inc = ptr_i + ONE;
  assign ptr_dsp = ptr_i + AW'(disp_i);

  always_comb begin
    ea_o      = '0;
    wb_val_o  = '0;
    wb_need_o = 1'b0;
    illegal_o = 1'b0;
    case (mode_i)
      AM_DIRECT: ea_o = direct_i;
      AM_IND: begin
        if (sel_ok_i) ea_o = ptr_i;
        else          illegal_o = 1'b1;
      end
      AM_DISP: begin
        // only Y and Z may carry a displacement
        if (sel_ok_i && sel_i != PS_X) ea_o = ptr_dsp;
        else                           illegal_o = 1'b1;
      end
      AM_PREDEC: begin
        if (sel_ok_i) begin
          ea_o      = ptr_dec;
          wb_val_o  = ptr_dec;
          wb_need_o = 1'b1;
        end else illegal_o = 1'b1;
      end
      AM_POSTINC: begin
        if (sel_ok_i) begin
          ea_o      = ptr_i;
          wb_val_o  = ptr_inc;
          wb_need_o = 1'b1;
        end else illegal_o = 1'b1;
      end
      default: illegal_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/dmag_wb_reg.sv
module dmag_wb_reg
  import dmag_pkg::*;
#(
  parameter int unsigned AW   = ADDR_W,
  parameter int unsigned SW   = SEL_W,
  parameter int unsigned IW   = RIDX_W,
  parameter int unsigned BASE = PTR_BASE
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fire_i,
  input  logic [SW-1:0] sel_i,
  input  logic [AW-1:0] val_i,
  output logic          wb_en_o,
  output logic [IW-1:0] wb_idx_o,
  output logic [AW-1:0] wb_data_o
);
  logic [IW-1:0] idx_d;
  assign idx_d = IW'(BASE) + IW'({sel_i, 1'b0});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_en_o   <= 1'b0;
      wb_idx_o  <= '0;
      wb_data_o <= '0;
    end else begin
      wb_en_o <= fire_i;
      if (fire_i) begin
        wb_idx_o  <= idx_d;
        wb_data_o <= val_i;
      end
    end
  end
endmodule

// File: rtl/dmag_top.sv
module dmag_top
  import dmag_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DISP_W,
  parameter int unsigned NP = NUM_PTR,
  parameter int unsigned SW = SEL_W,
  parameter int unsigned IW = RIDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [SW-1:0]     ptr_sel_i,
  input  logic [DW-1:0]     disp_i,
  input  logic [AW-1:0]     direct_i,
  input  logic [2*NP*8-1:0] regs_i,
  output logic [AW-1:0]     ea_o,
  output logic              illegal_o,
  output logic              wb_en_o,
  output logic [IW-1:0]     wb_idx_o,
  output logic [AW-1:0]     wb_data_o
);
  logic [AW-1:0] ptr;
  logic          sel_ok;
  logic [AW-1:0] wb_val;
  logic          wb_need;

  dmag_ptr_mux #(.AW(AW), .NP(NP), .SW(SW)) u_mux (
    .regs_i  (regs_i),
    .sel_i   (ptr_sel_i),
    .ptr_o   (ptr),
    .sel_ok_o(sel_ok)
  );

  dmag_ea_calc #(.AW(AW), .DW(DW), .SW(SW)) u_calc (
    .mode_i   (mode_i),
    .sel_i    (ptr_sel_i),
    .sel_ok_i (sel_ok),
    .disp_i   (disp_i),
    .direct_i (direct_i),
    .ptr_i    (ptr),
    .ea_o     (ea_o),
    .wb_val_o (wb_val),
    .wb_need_o(wb_need),
    .illegal_o(illegal_o)
  );

  dmag_wb_reg #(.AW(AW), .SW(SW), .IW(IW), .BASE(PTR_BASE)) u_wb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (req_i & wb_need),
    .sel_i    (ptr_sel_i),
    .val_i    (wb_val),
    .wb_en_o  (wb_en_o),
    .wb_idx_o (wb_idx_o),
    .wb_data_o(wb_data_o)
  );
endmodule

// File: rtl/dmag_chk.sv
module dmag_chk
  import dmag_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic [MODE_W-1:0]   mode_i,
  input logic [ADDR_W-1:0]   direct_i,
  input logic [ADDR_W-1:0]   ea_o,
  input logic                illegal_o,
  input logic                wb_en_o,
  input logic [RIDX_W-1:0]   wb_idx_o,
  input logic [ADDR_W-1:0]   wb_data_o
);
  AST_WB_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> $past(req_i)) else $error("wb without req"); // R7

  AST_WB_MODE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> ($past(mode_i) == AM_PREDEC || $past(mode_i) == AM_POSTINC)) else $error("wb in wrong mode"); // R7

  AST_ILLEGAL_NO_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> !$past(illegal_o)) else $error("wb after illegal"); // R6

  AST_PREDEC_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_en_o && $past(mode_i) == AM_PREDEC) |-> wb_data_o == $past(ea_o)) else $error("predec wb"); // R3

  AST_POSTINC_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_en_o && $past(mode_i) == AM_POSTINC) |-> wb_data_o == $past(ea_o) + 16'd1) else $error("postinc wb"); // R4

  AST_IDX_EVEN_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> (wb_idx_o == 5'd26 || wb_idx_o == 5'd28 || wb_idx_o == 5'd30)) else $error("bad idx"); // R2

  AST_DIRECT_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == AM_DIRECT) |-> (ea_o == direct_i && !illegal_o)) else $error("direct ea"); // R1

  AST_ILLEGAL_ZERO_EA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> ea_o == '0) else $error("illegal ea"); // R6
endmodule

bind dmag_top dmag_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .mode_i   (mode_i),
  .direct_i (direct_i),
  .ea_o     (ea_o),
  .illegal_o(illegal_o),
  .wb_en_o  (wb_en_o),
  .wb_idx_o (wb_idx_o),
  .wb_data_o(wb_data_o)
);

// File: tb/tb_dmag_top.sv
module tb_dmag_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [2:0]  mode_i = '0;
  logic [1:0]  ptr_sel_i = '0;
  logic [5:0]  disp_i = '0;
  logic [15:0] direct_i = '0;
  logic [47:0] regs_i = '0;
  logic [15:0] ea_o;
  logic        illegal_o;
  logic        wb_en_o;
  logic [4:0]  wb_idx_o;
  logic [15:0] wb_data_o;

  int compared = 0;
  int mismatched = 0;
  logic        p_en;
  logic [4:0]  p_idx;
  logic [15:0] p_data;

  always #5 clk_i = ~clk_i;

  dmag_top dut (.*);

  initial begin
    #1_000_000;
    mismatched++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void model(input logic [2:0] m, input logic [1:0] s,
      input logic [5:0] d, input logic [15:0] dir, input logic [47:0] r,
      output logic [15:0] ea, output logic ill, output logic wbn,
      output logic [15:0] wbv, output string tag);
    logic [15:0] p;
    p = (s < 2'd3) ? {r[(2*s+1)*8 +: 8], r[(2*s)*8 +: 8]} : 16'h0;
    ea = 16'h0; ill = 1'b0; wbn = 1'b0; wbv = 16'h0;
    case (m)
      3'd0: begin ea = dir; tag = "R1"; end
      3'd1: begin tag = "R2"; if (s == 2'd3) ill = 1'b1; else ea = p; end
      3'd2: begin tag = "R5"; if (s == 2'd3 || s == 2'd0) ill = 1'b1; else ea = p + {10'd0, d}; end
      3'd3: begin tag = "R3"; if (s == 2'd3) ill = 1'b1; else begin ea = p - 16'd1; wbv = ea; wbn = 1'b1; end end
      3'd4: begin tag = "R4"; if (s == 2'd3) ill = 1'b1; else begin ea = p; wbv = p + 16'd1; wbn = 1'b1; end end
      default: begin tag = "R6"; ill = 1'b1; end
    endcase
    if (ill) tag = "R6";
  endfunction

  task automatic step(logic rq, logic [2:0] m, logic [1:0] s, logic [5:0] d,
      logic [15:0] dir, logic [47:0] r);
    logic [15:0] ea, wbv;
    logic ill, wbn;
    string tag;
    @(negedge clk_i);
    chk("R7 wb_en", {31'd0, wb_en_o}, {31'd0, p_en});
    if (p_en) begin
      chk("R2 wb_idx", {27'd0, wb_idx_o}, {27'd0, p_idx});
      chk("R7 wb_data", {16'd0, wb_data_o}, {16'd0, p_data});
    end
    req_i = rq; mode_i = m; ptr_sel_i = s; disp_i = d; direct_i = dir; regs_i = r;
    #1;
    model(m, s, d, dir, r, ea, ill, wbn, wbv, tag);
    chk({tag, " ea"}, {16'd0, ea_o}, {16'd0, ea});
    chk({tag, " illegal"}, {31'd0, illegal_o}, {31'd0, ill});
    p_en = rq && wbn;
    p_idx = 5'd26 + {2'd0, s, 1'b0};
    p_data = wbv;
  endtask

  initial begin
    void'($urandom(32'd1234));
    p_en = 1'b0; p_idx = '0; p_data = '0;
    #12;
    chk("R8 wb_en reset", {31'd0, wb_en_o}, 32'd0);
    chk("R8 wb_data reset", {16'd0, wb_data_o}, 32'd0);
    chk("R8 wb_idx reset", {27'd0, wb_idx_o}, 32'd0);
    @(negedge clk_i); rst_ni = 1'b1;
    // directed: X=0x0000, Y=0xFFC1, Z=0xFFFF
    step(1, 3'd3, 2'd0, 6'd0, 16'h0, 48'hFFFF_FFC1_0000);
    step(1, 3'd4, 2'd2, 6'd0, 16'h0, 48'hFFFF_FFC1_0000);
    step(1, 3'd2, 2'd1, 6'd63, 16'h0, 48'hFFFF_FFC1_0000);
    step(1, 3'd2, 2'd0, 6'd5, 16'h0, 48'hFFFF_FFC1_0000);
    step(1, 3'd4, 2'd3, 6'd0, 16'h0, 48'hFFFF_FFC1_0000);
    step(1, 3'd6, 2'd1, 6'd0, 16'h0, 48'hFFFF_FFC1_0000);
    step(1, 3'd0, 2'd3, 6'd9, 16'hBEEF, 48'h1234_5678_9ABC);
    step(1, 3'd1, 2'd0, 6'd0, 16'h0, 48'h1234_5678_9ABC);
    step(0, 3'd4, 2'd1, 6'd0, 16'h0, 48'h1234_5678_9ABC);
    step(1, 3'd3, 2'd1, 6'd0, 16'h0, 48'h1234_5678_9ABC);
    step(0, 3'd0, 2'd0, 6'd0, 16'h0, 48'h1234_5678_9ABC);
    for (int i = 0; i < 3000; i++) begin
      step(1'($urandom), 3'($urandom), 2'($urandom), 6'($urandom), 16'($urandom),
           {16'($urandom), 32'($urandom)});
    end
    step(0, 3'd0, 2'd0, 6'd0, 16'h0, 48'h0);
    step(0, 3'd0, 2'd0, 6'd0, 16'h0, 48'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule